// File: doc/BRIEF.md
# Floating-Point Control/Status Register

This block holds the two pieces of floating-point control state that software and the arithmetic datapath share: a three-bit rounding-mode selector and a five-bit set of sticky exception flags. Together they form one 32-bit word. Three CSR addresses reach that word: one exposes only the flags, one exposes only the rounding mode, and one exposes both packed together. All three views see the same storage, so a write through one view is visible through the others at once.

The datapath reports exceptions through an accrual input. Each reported bit is ORed into the stored flags, and accrual never clears a flag. The block drives a one-cycle dirty pulse to the machine status logic whenever the floating-point context really changes. A CSR write that hits any view always raises the pulse. An accrual raises it only if the OR actually alters the stored flags. Privilege checks, rounding-mode legality and the machine status register itself sit outside this block.

Top module: `fcsr_unit`

## Requirements
- R1: After a synchronous active-low reset, the rounding mode and the flags are both zero and `dirty_o` is low.
- R2: Reads are combinational. Address 0x001 returns the flags in bits 4..0. Address 0x002 returns the rounding mode in bits 2..0. Address 0x003 returns the flags in bits 4..0 and the rounding mode in bits 7..5. All other bits read zero.
- R3: A write to 0x003 loads the flags from `csr_wdata[4:0]` and the rounding mode from `csr_wdata[7:5]`. Bits 31..8 of the write data are ignored.
- R4: A write to 0x001 loads only the flags from `csr_wdata[4:0]`, and the rounding mode is unchanged. A write to 0x002 loads only the rounding mode from `csr_wdata[2:0]`, and the flags are unchanged.
- R5: The rounding mode stores every 3-bit code, including 5, 6 and 7, and `rm_o` presents it from the cycle after the write.
- R6: When `exc_valid` is high, `exc_flags` is ORed into the stored flags at the clock edge. Accrual never clears a flag.
- R7: Any CSR write that hits one of the three addresses makes `dirty_o` high for the following cycle.
- R8: An accrual raises `dirty_o` for the following cycle only if it sets at least one flag that was clear. An accrual that changes nothing leaves `dirty_o` low.
- R9: When a CSR write and an accrual occur in the same cycle, the written value is applied first and the accrued bits are ORed onto it.
- R10: A write to any other address changes no state and raises no dirty pulse. For such an address `csr_hit` is low and the read data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_addr | input | 12 | CSR address for both read and write |
| csr_wr_en | input | 1 | Write strobe for the addressed view |
| csr_wdata | input | 32 | Write data, right-justified per view |
| csr_rdata | output | 32 | Combinational read data of the addressed view |
| csr_hit | output | 1 | Address matches one of the three views |
| exc_valid | input | 1 | Exception accrual strobe from the datapath |
| exc_flags | input | 5 | Exception bits to OR into the flags |
| rm_o | output | 3 | Stored rounding mode for the datapath |
| dirty_o | output | 1 | One-cycle pulse: floating-point context changed |

## Verification
The bound checker watches several behaviours on every cycle. It checks the reset state and confirms that flags stay sticky under accrual alone. It checks that every hitting write produces a dirty pulse and that an accrual which adds no new flag produces none. It checks that idle cycles leave the state and `dirty_o` untouched, that a flags-only write leaves the rounding mode alone, and that the packed view matches the stored fields and reads zero in its upper bits. Only the bench scenarios can show the full arithmetic: every byte written through the packed view, every flag start value combined with every accrual pattern, the ordering of a write and an accrual that arrive in the same cycle, and the exact read-back of each view.

// File: rtl/fcsr_pkg.sv
// Shared field widths, view encoding and packed state type for the
// floating-point control/status register. Assumes the field layout is
// fixed: flags in the low bits, rounding mode directly above them.
package fcsr_pkg;
    localparam int FLAG_W  = 5;
    localparam int RM_W    = 3;
    localparam int FIELD_W = FLAG_W + RM_W;

    typedef enum logic [1:0] {
        VIEW_NONE  = 2'd0,
        VIEW_FLAGS = 2'd1,
        VIEW_RM    = 2'd2,
        VIEW_ALL   = 2'd3
    } view_e;

    typedef struct packed {
        logic [RM_W-1:0]   rm;
        logic [FLAG_W-1:0] flags;
    } fstate_t;
endpackage

// File: rtl/fcsr_decode.sv
// Maps a CSR address onto one of the three register views.
// Assumes the three view addresses are distinct.
module fcsr_decode #(
    parameter int          ADDR_W     = 12,
    parameter logic [11:0] ADDR_FLAGS = 12'h001,
    parameter logic [11:0] ADDR_RM    = 12'h002,
    parameter logic [11:0] ADDR_ALL   = 12'h003
) (
    input  logic [ADDR_W-1:0] addr,
    output fcsr_pkg::view_e   view
);
    // Compare the address against each view address.
    always_comb begin
        if (addr == ADDR_W'(ADDR_FLAGS))      view = fcsr_pkg::VIEW_FLAGS;
        else if (addr == ADDR_W'(ADDR_RM))    view = fcsr_pkg::VIEW_RM;
        else if (addr == ADDR_W'(ADDR_ALL))   view = fcsr_pkg::VIEW_ALL;
        else                                  view = fcsr_pkg::VIEW_NONE;
    end
endmodule

// File: rtl/fcsr_store.sv
// Holds the rounding mode and sticky flags. It applies a view write
// first and then ORs accrued exception bits on top. It produces a
// registered dirty pulse on a hitting write, or on an accrual that
// changes the flags. Assumes a synchronous active-low reset.
module fcsr_store #(
    parameter int DATA_W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  fcsr_pkg::view_e               view,
    input  logic [DATA_W-1:0]             wdata,
    input  logic                          acc_valid,
    input  logic [fcsr_pkg::FLAG_W-1:0]   acc_flags,
    output fcsr_pkg::fstate_t             state_q,
    output logic                          dirty_q
);
    import fcsr_pkg::*;

    fstate_t           base;
    fstate_t           state_d;
    logic [FLAG_W-1:0] acc_bits;
    logic              wr_hit;
    logic              acc_change;
    logic              dirty_d;

    // Apply the addressed field write to the current state.
    always_comb begin
        base   = state_q;
        wr_hit = wr_en && (view != VIEW_NONE);
        if (wr_en) begin
            unique case (view)
                VIEW_FLAGS: base.flags = wdata[FLAG_W-1:0];
                VIEW_RM:    base.rm    = wdata[RM_W-1:0];
                VIEW_ALL:   base       = wdata[FIELD_W-1:0];
                default:    base       = state_q;
            endcase
        end
    end

    // OR the accrued bits onto the post-write value and detect a real change.
    always_comb begin
        acc_bits      = acc_valid ? acc_flags : '0;
        state_d       = base;
        state_d.flags = base.flags | acc_bits;
        acc_change    = (state_d.flags != base.flags);
        dirty_d       = wr_hit || acc_change;
    end

    // Register the state and the dirty pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
            dirty_q <= 1'b0;
        end else begin
            state_q <= state_d;
            dirty_q <= dirty_d;
        end
    end
endmodule

// File: rtl/fcsr_readmux.sv
// Selects the addressed view for a read, right-justified and zero-filled.
// Assumes DATA_W is at least the packed field width.
module fcsr_readmux #(
    parameter int DATA_W = 32
) (
    input  fcsr_pkg::view_e   view,
    input  fcsr_pkg::fstate_t state,
    output logic [DATA_W-1:0] rdata
);
    import fcsr_pkg::*;

    // Pick the field(s) for the addressed view.
    always_comb begin
        rdata = '0;
        unique case (view)
            VIEW_FLAGS: rdata[FLAG_W-1:0]  = state.flags;
            VIEW_RM:    rdata[RM_W-1:0]    = state.rm;
            VIEW_ALL:   rdata[FIELD_W-1:0] = state;
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/fcsr_unit.sv
// Top of the floating-point control/status register. It ties address
// decode, the storage with accrual, and the read mux together, and
// exposes the rounding mode and a dirty pulse. Assumes the caller has
// already resolved privilege and rounding-mode legality.
module fcsr_unit #(
    parameter int          ADDR_W     = 12,
    parameter int          DATA_W     = 32,
    parameter logic [11:0] ADDR_FLAGS = 12'h001,
    parameter logic [11:0] ADDR_RM    = 12'h002,
    parameter logic [11:0] ADDR_ALL   = 12'h003
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] csr_addr,
    input  logic              csr_wr_en,
    input  logic [DATA_W-1:0] csr_wdata,
    output logic [DATA_W-1:0] csr_rdata,
    output logic              csr_hit,
    input  logic              exc_valid,
    input  logic [4:0]        exc_flags,
    output logic [2:0]        rm_o,
    output logic              dirty_o
);
    import fcsr_pkg::*;

    view_e   view;
    fstate_t state_q;

    fcsr_decode #(
        .ADDR_W(ADDR_W), .ADDR_FLAGS(ADDR_FLAGS),
        .ADDR_RM(ADDR_RM), .ADDR_ALL(ADDR_ALL)
    ) u_decode (
        .addr(csr_addr),
        .view(view)
    );

    fcsr_store #(.DATA_W(DATA_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (csr_wr_en),
        .view     (view),
        .wdata    (csr_wdata),
        .acc_valid(exc_valid),
        .acc_flags(exc_flags),
        .state_q  (state_q),
        .dirty_q  (dirty_o)
    );

    fcsr_readmux #(.DATA_W(DATA_W)) u_rmux (
        .view (view),
        .state(state_q),
        .rdata(csr_rdata)
    );

    // Drive the hit flag and the rounding-mode output.
    always_comb begin
        csr_hit = (view != VIEW_NONE);
        rm_o    = state_q.rm;
    end
endmodule

// File: rtl/fcsr_unit_chk.sv
// Cycle-by-cycle properties of fcsr_unit, bound to every instance.
// Assumes the flags field is brought out of the top as flags_q.
module fcsr_unit_chk #(
    parameter int          ADDR_W     = 12,
    parameter int          DATA_W     = 32,
    parameter logic [11:0] ADDR_FLAGS = 12'h001,
    parameter logic [11:0] ADDR_ALL   = 12'h003
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] csr_addr,
    input logic              csr_wr_en,
    input logic [DATA_W-1:0] csr_rdata,
    input logic              csr_hit,
    input logic              exc_valid,
    input logic [4:0]        exc_flags,
    input logic [2:0]        rm_o,
    input logic              dirty_o,
    input logic [4:0]        flags_q
);
    localparam int FW = 8;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (rm_o == 3'd0) && (flags_q == 5'd0) && !dirty_o);

    // R6
    sticky_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && !csr_wr_en) |=>
            ((flags_q & $past(exc_flags)) == $past(exc_flags)) &&
            ((flags_q & $past(flags_q)) == $past(flags_q)));

    // R7
    wr_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wr_en && csr_hit) |=> dirty_o);

    // R8
    acc_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!csr_wr_en && exc_valid && ((exc_flags & ~flags_q) == 5'd0)) |=> !dirty_o);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(csr_wr_en && csr_hit) && !exc_valid) |=>
            !dirty_o && $stable(rm_o) && $stable(flags_q));

    // R4
    flags_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wr_en && csr_addr == ADDR_W'(ADDR_FLAGS)) |=> $stable(rm_o));

    // R2
    packed_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_addr == ADDR_W'(ADDR_ALL)) |->
            (csr_rdata[FW-1:0] == {rm_o, flags_q}) && (csr_rdata[DATA_W-1:FW] == '0));
endmodule

bind fcsr_unit fcsr_unit_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .ADDR_FLAGS(ADDR_FLAGS), .ADDR_ALL(ADDR_ALL)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .csr_addr (csr_addr),
    .csr_wr_en(csr_wr_en),
    .csr_rdata(csr_rdata),
    .csr_hit  (csr_hit),
    .exc_valid(exc_valid),
    .exc_flags(exc_flags),
    .rm_o     (rm_o),
    .dirty_o  (dirty_o),
    .flags_q  (state_q.flags)
);

// File: tb/fcsr_unit_tb.sv
// Sweep bench for fcsr_unit: a bench-side model tracks rm and flags.
module fcsr_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] csr_addr = 12'h003;
    logic        csr_wr_en = 1'b0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        csr_hit;
    logic        exc_valid = 1'b0;
    logic [4:0]  exc_flags = '0;
    logic [2:0]  rm_o;
    logic        dirty_o;

    int total = 0;
    int bad = 0;
    logic [4:0] mf = '0;
    logic [2:0] mr = '0;

    fcsr_unit u_dut (
        .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_wr_en(csr_wr_en),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .csr_hit(csr_hit),
        .exc_valid(exc_valid), .exc_flags(exc_flags), .rm_o(rm_o), .dirty_o(dirty_o)
    );

    always #4 clk = ~clk;

    task automatic check(input logic ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // One cycle of stimulus, followed by checks of the dirty pulse, rm_o and the packed read-back.
    task automatic step(input logic wr, input logic [11:0] a, input logic [31:0] d,
                        input logic ev, input logic [4:0] ef, input string tag);
        logic hit;
        logic [4:0] nf;
        logic [2:0] nr;
        logic exp_dirty;
        @(negedge clk);
        csr_wr_en = wr; csr_addr = a; csr_wdata = d; exc_valid = ev; exc_flags = ef;
        hit = (a == 12'h001) || (a == 12'h002) || (a == 12'h003);
        nf = mf; nr = mr;
        if (wr && a == 12'h001) nf = d[4:0];
        if (wr && a == 12'h002) nr = d[2:0];
        if (wr && a == 12'h003) begin nf = d[4:0]; nr = d[7:5]; end
        exp_dirty = (wr && hit) || (ev && ((nf | ef) != nf));
        if (ev) nf = nf | ef;
        mf = nf; mr = nr;
        @(posedge clk);
        #1;
        csr_wr_en = 1'b0; exc_valid = 1'b0;
        check(dirty_o == exp_dirty, tag, "dirty", 32'(dirty_o), 32'(exp_dirty));
        check(rm_o == mr, tag, "rm_o", 32'(rm_o), 32'(mr));
        csr_addr = 12'h003;
        #1;
        check(csr_rdata == {24'h0, mr, mf}, tag, "packed read", csr_rdata, {24'h0, mr, mf});
    endtask

    task automatic read_view(input logic [11:0] a, input logic [31:0] exp,
                             input logic exp_hit, input string tag);
        @(negedge clk);
        csr_addr = a;
        #1;
        check(csr_rdata == exp, tag, "view read", csr_rdata, exp);
        check(csr_hit == exp_hit, tag, "hit", 32'(csr_hit), 32'(exp_hit));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check(rm_o == 3'd0, "R1", "rm after reset", 32'(rm_o), 0);
        check(dirty_o == 1'b0, "R1", "dirty after reset", 32'(dirty_o), 0);
        check(csr_rdata == 32'd0, "R1", "packed after reset", csr_rdata, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R3: every low byte through the packed view, with junk in the upper bits
        for (int v = 0; v < 256; v++)
            step(1'b1, 12'h003, {8'(v * 37 + 5), 16'(v * 911), 8'(v)}, 1'b0, 5'd0, "R3");

        // R4 / R5: single-field writes, including reserved rounding codes
        step(1'b1, 12'h003, 32'h0000_00A5, 1'b0, 5'd0, "R3");
        for (int v = 0; v < 32; v++)
            step(1'b1, 12'h001, 32'hFFFF_FF00 | 32'(v), 1'b0, 5'd0, "R4");
        for (int v = 0; v < 8; v++)
            step(1'b1, 12'h002, 32'hFFFF_FFF8 | 32'(v), 1'b0, 5'd0, "R5");

        // R2: each view read right-justified
        step(1'b1, 12'h003, 32'h0000_00D3, 1'b0, 5'd0, "R2");
        read_view(12'h001, 32'h13, 1'b1, "R2");
        read_view(12'h002, 32'h6, 1'b1, "R2");
        read_view(12'h003, 32'hD3, 1'b1, "R2");

        // R6 / R8: every start value against every accrual pattern
        for (int s = 0; s < 32; s++)
            for (int e = 0; e < 32; e++) begin
                step(1'b1, 12'h001, 32'(s), 1'b0, 5'd0, "R7");
                step(1'b0, 12'h003, 32'd0, 1'b1, 5'(e), "R8");
            end
        step(1'b0, 12'h003, 32'd0, 1'b1, 5'd0, "R6");

        // R9: write and accrual in the same cycle, on each view
        step(1'b1, 12'h001, 32'h0000_0001, 1'b1, 5'h10, "R9");
        step(1'b1, 12'h003, 32'h0000_0000, 1'b1, 5'h03, "R9");
        step(1'b1, 12'h002, 32'h0000_0007, 1'b1, 5'h04, "R9");
        step(1'b1, 12'h001, 32'h0000_001F, 1'b1, 5'h1F, "R9");

        // R10: unmapped addresses are ignored
        step(1'b1, 12'h003, 32'h0000_0049, 1'b0, 5'd0, "R3");
        step(1'b1, 12'h000, 32'hFFFF_FFFF, 1'b0, 5'd0, "R10");
        step(1'b1, 12'h004, 32'hFFFF_FFFF, 1'b0, 5'd0, "R10");
        step(1'b1, 12'hFFF, 32'hFFFF_FFFF, 1'b0, 5'd0, "R10");
        step(1'b1, 12'h301, 32'hFFFF_FFFF, 1'b0, 5'd0, "R10");
        read_view(12'h000, 32'd0, 1'b0, "R10");
        read_view(12'h103, 32'd0, 1'b0, "R10");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule